// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that behaves like a small serial EEPROM of 256 bytes with a 16-byte page buffer. It oversamples the bus clock and data lines with the system clock, finds start and stop conditions, and answers only to the 7-bit device address formed by the fixed prefix `1010` and the levels on three chip-select pins. It never drives SDA high. It only pulls it low through `sda_oe`, to acknowledge and to send read data. Outside the block, SDA is wired-AND with the other drivers and a pull-up.

A write transfer loads the word pointer from its first data byte. Each later byte lands in the page buffer at the pointer's low four bits, and those bits then advance and wrap inside the page, so a long burst overwrites its own earlier bytes. The buffered page goes into the array when the stop condition arrives. After that the block ignores its address for a programmable number of cycles, as a stand-in for a self-timed programming cycle. A read transfer returns bytes from the pointer onward, most significant bit first. The pointer runs across the whole array and wraps from 0xFF to 0x00.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The block drives `sda_oe` high during the ninth clock of an address byte only when bits 7..1 of that byte equal `1010` followed by `chip_sel[2:0]` (bit 7 first). For any other address it keeps `sda_oe` low for the rest of the transfer.
- R2: A falling SDA while SCL is high is a start condition and a rising SDA while SCL is high is a stop condition. A start at any point, including partway through a byte, restarts reception of a fresh address byte from its first bit.
- R3: After an address byte whose bit 0 is 0 (write), the first following byte loads the word pointer and discards any page data received but not yet committed.
- R4: Each later write byte is acknowledged and buffered at the pointer's low four bits. Only those four bits then increment and wrap, so the 17th byte of a burst replaces the 1st.
- R5: Buffered bytes are written into the array on the stop condition. Array contents after reset are 0xFF.
- R6: A stop that commits data makes the block refuse to acknowledge its own address for `BUSY_CYCLES` clock cycles. A stop with nothing buffered does not start this window.
- R7: While `wp` is high, write bytes are still acknowledged but are not buffered and never reach the array.
- R8: After an address byte whose bit 0 is 1 (read), the block sends the byte at the word pointer MSB first, pulling SDA low for 0 bits and releasing it for 1 bits. A read directly after a start continues from the current pointer.
- R9: Each byte read advances the full 8-bit pointer, wrapping from 0xFF to 0x00.
- R10: The block releases SDA during the acknowledge slot of every read byte. On a not-acknowledge from the master it stops sending and leaves SDA released until the next start or stop.
- R11: `sda_oe` changes only after a detected falling edge of SCL, never while SCL is high.
- R12: After reset `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (after wired-AND) |
| chip_sel | input | 3 | Low three bits of the device address |
| wp | input | 1 | Write protect; high blocks all array updates |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The stop condition that commits a page does three things in one clock edge: it writes the array, clears the pending mask and loads the busy counter. Addressing the device straight after that stop must then be refused. The bench provokes this by sending the device address immediately after a committing stop and expecting a released acknowledge slot. It then waits out the window and reads the page back against its own model. A second collision happens when the read pointer reaches 0xFF just as the next byte is fetched. The bench reads across that wrap and expects the data from address 0x00.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         MEM_BYTES   = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_DACK = 3'd2,
                         S_WR = 3'd3, S_WACK = 3'd4, S_RD = 3'd5, S_RACK = 3'd6;

  logic [2:0] scl_s, sda_s;
  logic [2:0] state, bitcnt;
  logic       done, first, nack;
  logic [7:0] shreg;
  logic [6:0] txbits;
  logic [AW-1:0] addr;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [CW-1:0] busy;
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  wire scl_rise  = scl_s[1] & ~scl_s[2];
  wire scl_fall  = ~scl_s[1] & scl_s[2];
  wire sda_bit   = sda_s[1];
  wire start_det = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire stop_det  = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];

  wire [7:0]    rx_byte = {shreg[6:0], sda_bit};
  wire [PW-1:0] poff    = addr[PW-1:0];
  wire [7:0]    rd_data = mem[addr];
  wire          hit     = (shreg[7:1] == {DEV_ID, chip_sel}) && (busy == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      done   <= 1'b0;
      first  <= 1'b0;
      nack   <= 1'b0;
      shreg  <= '0;
      txbits <= '0;
      addr   <= '0;
      pmask  <= '0;
      busy   <= '0;
      sda_oe <= 1'b0;
    end else begin
      if (busy != '0) busy <= busy - CW'(1);
      if (start_det) begin
        state  <= S_DEV;
        bitcnt <= '0;
        done   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        done   <= 1'b0;
        sda_oe <= 1'b0;
        if (|pmask) begin
          pmask <= '0;
          busy  <= CW'(BUSY_CYCLES);
        end
      end else if (scl_rise) begin
        case (state)
          S_DEV, S_WR: begin
            shreg  <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              done <= 1'b1;
              if (state == S_WR) begin
                if (first) begin
                  addr  <= rx_byte[AW-1:0];
                  first <= 1'b0;
                  pmask <= '0;
                end else begin
                  if (!wp) begin
                    pbuf[poff]  <= rx_byte;
                    pmask[poff] <= 1'b1;
                  end
                  addr[PW-1:0] <= poff + PW'(1);
                end
              end
            end
          end
          S_RD: begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              done <= 1'b1;
              addr <= addr + AW'(1);
            end
          end
          S_RACK: nack <= sda_bit;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          S_DEV: if (done) begin
            done <= 1'b0;
            if (hit) begin
              sda_oe <= 1'b1;
              state  <= S_DACK;
            end else begin
              state <= S_IDLE;
            end
          end
          S_DACK: begin
            bitcnt <= '0;
            if (shreg[0]) begin
              txbits <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              first  <= 1'b1;
              state  <= S_WR;
            end
          end
          S_WR: if (done) begin
            done   <= 1'b0;
            sda_oe <= 1'b1;
            state  <= S_WACK;
          end
          S_WACK: begin
            sda_oe <= 1'b0;
            state  <= S_WR;
          end
          S_RD: begin
            if (done) begin
              done   <= 1'b0;
              sda_oe <= 1'b0;
              state  <= S_RACK;
            end else begin
              txbits <= {txbits[5:0], 1'b0};
              sda_oe <= ~txbits[6];
            end
          end
          S_RACK: begin
            if (!nack) begin
              txbits <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              state  <= S_RD;
            end else begin
              state <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (stop_det) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
    end
  end
endmodule

module eeprom_i2c_slave_chk #(
  parameter logic [3:0] DEV_ID     = 4'b1010,
  parameter int         PAGE_BYTES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_oe,
  input logic                  scl_was_hi,
  input logic                  in_dack,
  input logic                  in_rack,
  input logic                  may_drive,
  input logic                  busy_zero,
  input logic [7:0]            addr_byte,
  input logic [2:0]            chip_sel,
  input logic                  wp,
  input logic [PAGE_BYTES-1:0] pmask,
  input logic                  stop_det
);
  // R11
  oe_only_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_was_hi));
  // R1
  ack_only_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_dack |-> addr_byte[7:1] == {DEV_ID, chip_sel});
  // R6
  no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_dack |-> busy_zero);
  // R7
  wp_blocks_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp |=> (pmask & ~$past(pmask)) == '0);
  // R5
  stop_drains_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> pmask == '0);
  // R10
  rd_ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rack |-> !sda_oe);
  // R8
  drive_in_legal_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> may_drive);
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.DEV_ID(DEV_ID), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe     (sda_oe),
  .scl_was_hi (scl_s[1]),
  .in_dack    (state == S_DACK),
  .in_rack    (state == S_RACK),
  .may_drive  (state == S_DACK || state == S_WACK || state == S_RD),
  .busy_zero  (busy == '0),
  .addr_byte  (shreg),
  .chip_sel   (chip_sel),
  .wp         (wp),
  .pmask      (pmask),
  .stop_det   (stop_det)
);

// File: tb/test_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module test_eeprom_i2c_slave;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] chip_sel = 3'b101;
  logic wp = 1'b0;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  eeprom_i2c_slave #(.BUSY_CYCLES(BUSY)) i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .chip_sel(chip_sel), .wp(wp), .sda_oe(sda_oe));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit chk_on = 0, exp_oe = 0, slot_bad = 0;

  logic [7:0] mm [256];
  logic [7:0] pb [16];
  bit         pm [16];
  logic [7:0] ma;

  always @(negedge clk) begin
    #1;
    if (chk_on && sda_oe !== exp_oe) slot_bad = 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic bitx(input bit mb, input bit eo, input string tag, output bit seen);
    slot_bad = 0;
    repeat (3) @(negedge clk); sda_m = mb;
    repeat (5) @(negedge clk); exp_oe = eo; chk_on = 1;
    repeat (2) @(negedge clk); scl = 1;
    repeat (5) @(negedge clk); seen = sda_bus;
    repeat (5) @(negedge clk); chk_on = 0; scl = 0;
    check(!slot_bad, {tag, " R11 slot"}, slot_bad ? int'(!eo) : int'(eo), int'(eo));
  endtask

  task automatic do_start();
    chk_on = 0;
    if (!scl) begin
      repeat (3) @(negedge clk); sda_m = 1;
      repeat (5) @(negedge clk); scl = 1;
    end
    repeat (5) @(negedge clk); sda_m = 0;
    repeat (5) @(negedge clk); scl = 0;
  endtask

  task automatic do_stop(output bit committed);
    chk_on = 0;
    repeat (3) @(negedge clk); sda_m = 0;
    repeat (5) @(negedge clk); scl = 1;
    repeat (5) @(negedge clk); sda_m = 1;
    repeat (5) @(negedge clk);
    committed = 0;
    for (int j = 0; j < 16; j++)
      if (pm[j]) begin
        mm[{ma[7:4], 4'(j)}] = pb[j];
        pm[j] = 0;
        committed = 1;
      end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ea, input string tag);
    bit s;
    for (int i = 7; i >= 0; i--) bitx(b[i], 1'b0, tag, s);
    bitx(1'b1, ea, tag, s);
  endtask

  task automatic recv_byte(input bit mack, input string tag);
    logic [7:0] got, expv;
    bit s;
    expv = mm[ma];
    ma = ma + 8'd1;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, ~expv[i], tag, s);
      got[i] = s;
    end
    bitx(!mack, 1'b0, {tag, " R10"}, s);
    check(got == expv, tag, got, expv);
  endtask

  function automatic void m_word(input logic [7:0] wa);
    ma = wa;
    for (int j = 0; j < 16; j++) pm[j] = 0;
  endfunction

  task automatic wr_burst(input logic [7:0] wa, input int n, input logic [7:0] seed,
                          input string tag, input bit wait_busy);
    logic [7:0] d;
    bit c;
    do_start();
    send_byte({4'hA, chip_sel, 1'b0}, 1'b1, {tag, " R1"});
    send_byte(wa, 1'b1, {tag, " R3"});
    m_word(wa);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 7);
      send_byte(d, 1'b1, tag);
      if (!wp) begin
        pb[ma[3:0]] = d;
        pm[ma[3:0]] = 1;
      end
      ma[3:0] = ma[3:0] + 4'd1;
    end
    do_stop(c);
    if (c && wait_busy) repeat (BUSY + 50) @(negedge clk);
  endtask

  task automatic rd_tail(input int n, input string tag);
    bit c, s;
    send_byte({4'hA, chip_sel, 1'b1}, 1'b1, {tag, " R8"});
    for (int k = 0; k < n; k++) recv_byte(k < n - 1, tag);
    bitx(1'b1, 1'b0, "R10 after nack", s);
    do_stop(c);
  endtask

  task automatic rd_at(input logic [7:0] wa, input int n, input string tag);
    do_start();
    send_byte({4'hA, chip_sel, 1'b0}, 1'b1, {tag, " R1"});
    send_byte(wa, 1'b1, {tag, " R3"});
    m_word(wa);
    do_start();
    rd_tail(n, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit c, s;
    for (int j = 0; j < 256; j++) mm[j] = 8'hFF;
    for (int j = 0; j < 16; j++) begin pm[j] = 0; pb[j] = 0; end
    ma = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R12 reset", sda_oe, 0);

    // R1: wrong chip-select bits get no acknowledge and no later drive
    do_start();
    send_byte({4'hA, 3'b011, 1'b0}, 1'b0, "R1 mismatch");
    send_byte(8'h00, 1'b0, "R1 ignored");
    do_stop(c);
    // R1: wrong fixed prefix
    do_start();
    send_byte({4'hB, chip_sel, 1'b1}, 1'b0, "R1 prefix");
    do_stop(c);

    // R4/R5/R6: short write, then address straight after the committing stop
    wr_burst(8'h23, 4, 8'h40, "R4 write", 1'b0);
    do_start();
    send_byte({4'hA, chip_sel, 1'b0}, 1'b0, "R6 busy nack");
    do_stop(c);
    repeat (BUSY + 50) @(negedge clk);
    rd_at(8'h22, 6, "R5 readback");

    // R4: burst of 20 into page 0x30 wraps and overwrites
    wr_burst(8'h3C, 20, 8'h90, "R4 wrap", 1'b1);
    rd_at(8'h30, 16, "R4 page");

    // R9: read pointer wraps 0xFF -> 0x00
    wr_burst(8'hFE, 2, 8'h11, "R4 top", 1'b1);
    mm[8'h00] = mm[8'h00];
    rd_at(8'hFE, 4, "R9 wrap");

    // R7: write protect; no busy window since nothing is buffered
    wp = 1;
    wr_burst(8'h50, 3, 8'h5A, "R7 protected", 1'b0);
    rd_at(8'h50, 3, "R7 unchanged");
    wp = 0;

    // R3: second word address discards the uncommitted byte
    do_start();
    send_byte({4'hA, chip_sel, 1'b0}, 1'b1, "R3 dev");
    send_byte(8'h70, 1'b1, "R3 wa1");
    m_word(8'h70);
    send_byte(8'h11, 1'b1, "R3 data1");
    do_start();
    send_byte({4'hA, chip_sel, 1'b0}, 1'b1, "R3 dev2");
    send_byte(8'h80, 1'b1, "R3 wa2");
    m_word(8'h80);
    send_byte(8'h22, 1'b1, "R3 data2");
    pb[0] = 8'h22; pm[0] = 1; ma[3:0] = ma[3:0] + 4'd1;
    do_stop(c);
    repeat (BUSY + 50) @(negedge clk);
    rd_at(8'h70, 1, "R3 discarded");
    rd_at(8'h80, 1, "R3 kept");

    // R8: current-address read continues from the pointer
    do_start();
    rd_tail(2, "R8 current");

    // R2: start partway through an address byte restarts reception
    do_start();
    bitx(1'b0, 1'b0, "R2 partial", s);
    bitx(1'b1, 1'b0, "R2 partial", s);
    bitx(1'b1, 1'b0, "R2 partial", s);
    do_start();
    rd_tail(1, "R2 restart");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule